// File: doc/BRIEF.md
# Two-State Wrap-Around Add-Compare-Select Unit

This block is the path metric stage of a Viterbi decoder whose trellis has two states, S1 and S2. Each time the input strobe is high it takes four branch metrics, one for each trellis transition. It adds them to the two stored state metrics and keeps, for each next state, the smaller of its two candidate sums. For each state it reports which predecessor survived, as one decision bit that a downstream traceback memory stores.

The stored metrics grow without bound, so they are kept in a small register and allowed to wrap. There is no subtraction of a common offset. Two candidates are compared by the sign bit of their modular difference. The compare stays correct as long as the two candidates lie within half the register range of each other, and the bounded branch metrics keep them that close.

Top module: `acs2_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the S1 metric to 0, the S2 metric to INIT_OFFSET (default 64), both decision bits to 0 and outValid to 0.
- R2: On a clock edge with inValid high, the new S1 metric equals min(S1 + bmS1S1, S2 + bmS2S1), taken modulo 2^SM_W (SM_W defaults to 8).
- R3: On a clock edge with inValid high, the new S2 metric equals min(S1 + bmS1S2, S2 + bmS2S2), taken modulo 2^SM_W.
- R4: survivorBits[0] belongs to next state S1 and survivorBits[1] belongs to next state S2. A bit is 0 when the path from S1 survives and 1 when the path from S2 survives.
- R5: When the two candidate sums of a state are equal, its decision bit is 0, so the path from S1 is kept.
- R6: The decisions, the metrics and outValid update at the same clock edge that samples inValid high. outValid is high for exactly the cycles that follow an edge with inValid high, so back-to-back strobes give a continuous outValid.
- R7: On a clock edge with inValid low, the branch metric inputs are ignored. Both metrics and both decision bits hold their values, and outValid goes low.
- R8: The decisions and the low SM_W bits of the metrics match an unbounded-integer model over long sequences, including after the stored metrics have wrapped many times.
- R9: The modular difference S1 - S2 of the stored metrics, read as a signed value, stays within ±INIT_OFFSET at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Branch metrics are valid; enables the update |
| bmS1S1 | input | BM_W (5) | Branch metric for the transition S1 to S1 |
| bmS1S2 | input | BM_W (5) | Branch metric for the transition S1 to S2 |
| bmS2S1 | input | BM_W (5) | Branch metric for the transition S2 to S1 |
| bmS2S2 | input | BM_W (5) | Branch metric for the transition S2 to S2 |
| survivorBits | output | 2 | Decision per next state: bit 0 for S1, bit 1 for S2 |
| outValid | output | 1 | Decisions updated at the last edge |
| metricS1 | output | SM_W (8) | Stored S1 path metric (wraps) |
| metricS2 | output | SM_W (8) | Stored S2 path metric (wraps) |

## Verification
The main target is the wrap-around compare. Long random runs with large branch metrics drive the metrics through hundreds of wraps. A design that compares magnitudes instead of the sign of the modular difference would choose the wrong survivor whenever one candidate has wrapped and the other has not. Exact ties are forced on both states: a design that tests only the sign bit, and ignores a zero difference, would report 1 there. Idle cycles carry random branch metrics, which exposes any update that is not gated by the strobe. A check right after reset catches a wrong starting offset, because the first decisions would then start from the wrong state.

// File: rtl/acs2_pkg.sv
package acs2_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // take the new metrics and decisions
    logic clear;    // load the reset metrics
  } acsCtrl_t;
endpackage

// File: rtl/acs2_ctrl.sv
module acs2_ctrl
  import acs2_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output acsCtrl_t ctrl,
  output logic     outValid
);
  always_comb begin
    ctrl.clear   = rst;
    ctrl.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R6: a strobe yields valid output in the following cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R7: no valid output without a strobe
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/acs2_lane.sv
module acs2_lane #(
  parameter int BM_W = 5,
  parameter int SM_W = 8
) (
  input  logic [SM_W-1:0] metricFrom1,
  input  logic [SM_W-1:0] metricFrom2,
  input  logic [BM_W-1:0] bmFrom1,
  input  logic [BM_W-1:0] bmFrom2,
  output logic [SM_W-1:0] sumFrom1,
  output logic [SM_W-1:0] sumFrom2,
  output logic [SM_W-1:0] survivor,
  output logic            pick2
);
  localparam int PAD = SM_W - BM_W;

  logic [SM_W-1:0] diff;

  always_comb begin
    sumFrom1 = metricFrom1 + {{PAD{1'b0}}, bmFrom1};
    sumFrom2 = metricFrom2 + {{PAD{1'b0}}, bmFrom2};
    // modular difference: its MSB set means sumFrom1 is the smaller one
    diff     = sumFrom1 - sumFrom2;
    // the S2 path wins only when it is strictly smaller; a tie keeps S1
    pick2    = ~diff[SM_W-1] & (|diff);
    survivor = pick2 ? sumFrom2 : sumFrom1;
  end
endmodule

// File: rtl/acs2_datapath.sv
module acs2_datapath
  import acs2_pkg::*;
#(
  parameter int BM_W        = 5,
  parameter int SM_W        = 8,
  parameter int INIT_OFFSET = 64
) (
  input  logic            clk,
  input  acsCtrl_t        ctrl,
  input  logic [BM_W-1:0] bmS1S1,
  input  logic [BM_W-1:0] bmS1S2,
  input  logic [BM_W-1:0] bmS2S1,
  input  logic [BM_W-1:0] bmS2S2,
  output logic [1:0]      decisionQ,
  output logic [SM_W-1:0] metricS1,
  output logic [SM_W-1:0] metricS2
);
  localparam int NSTATE = 2;
  localparam int PAD    = SM_W - BM_W;
  localparam logic signed [SM_W-1:0] SPREAD_MAX = SM_W'(INIT_OFFSET);

  // the candidates must stay within half the register range
  if (INIT_OFFSET + (2 ** BM_W) >= (2 ** (SM_W - 1))) begin : g_bad_window
    $error("reset offset plus branch range exceeds the modular compare window");
  end

  logic [SM_W-1:0] metricQ   [NSTATE];
  logic [SM_W-1:0] survivorD [NSTATE];
  logic [SM_W-1:0] sum1      [NSTATE];
  logic [SM_W-1:0] sum2      [NSTATE];
  logic [BM_W-1:0] bmFrom1   [NSTATE];
  logic [BM_W-1:0] bmFrom2   [NSTATE];
  logic [NSTATE-1:0] pickD;

  always_comb begin
    bmFrom1[0] = bmS1S1;
    bmFrom2[0] = bmS2S1;
    bmFrom1[1] = bmS1S2;
    bmFrom2[1] = bmS2S2;
  end

  for (genvar i = 0; i < NSTATE; i++) begin : g_lane
    acs2_lane #(.BM_W(BM_W), .SM_W(SM_W)) lane_i (
      .metricFrom1 (metricQ[0]),
      .metricFrom2 (metricQ[1]),
      .bmFrom1     (bmFrom1[i]),
      .bmFrom2     (bmFrom2[i]),
      .sumFrom1    (sum1[i]),
      .sumFrom2    (sum2[i]),
      .survivor    (survivorD[i]),
      .pick2       (pickD[i])
    );
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear) begin
      metricQ[0] <= '0;
      metricQ[1] <= SM_W'(INIT_OFFSET);
      decisionQ  <= '0;
    end else if (ctrl.capture) begin
      for (int s = 0; s < NSTATE; s++) metricQ[s] <= survivorD[s];
      decisionQ <= pickD;
    end
  end

  assign metricS1 = metricQ[0];
  assign metricS2 = metricQ[1];

  logic [SM_W-1:0] padS1S1, padS1S2, padS2S1, padS2S2;
  logic signed [SM_W-1:0] spread;
  always_comb begin
    padS1S1 = {{PAD{1'b0}}, bmS1S1};
    padS1S2 = {{PAD{1'b0}}, bmS1S2};
    padS2S1 = {{PAD{1'b0}}, bmS2S1};
    padS2S2 = {{PAD{1'b0}}, bmS2S2};
    spread  = metricQ[0] - metricQ[1];
  end

  // R2, R4: the new S1 metric is the candidate that its decision bit names
  a_r2_s1_keeps_named: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.capture |=> metricQ[0] == (decisionQ[0] ? $past(metricQ[1] + padS2S1)
                                                 : $past(metricQ[0] + padS1S1)));
  // R3, R4: the same for S2
  a_r3_s2_keeps_named: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.capture |=> metricQ[1] == (decisionQ[1] ? $past(metricQ[1] + padS2S2)
                                                 : $past(metricQ[0] + padS1S2)));
  // R5: equal candidates keep the S1 path
  a_r5_tie_s1: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.capture && (sum1[0] == sum2[0]) |=> !decisionQ[0]);
  a_r5_tie_s2: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.capture && (sum1[1] == sum2[1]) |=> !decisionQ[1]);
  // R7: without a strobe nothing moves
  a_r7_hold: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.capture |=> $stable(metricQ[0]) && $stable(metricQ[1]) && $stable(decisionQ));
  // R9: the metrics stay inside the compare window
  a_r9_spread: assert property (@(posedge clk) disable iff (ctrl.clear)
    (spread <= SPREAD_MAX) && (spread >= -SPREAD_MAX));
endmodule

// File: rtl/acs2_unit.sv
module acs2_unit
  import acs2_pkg::*;
#(
  parameter int BM_W        = 5,
  parameter int SM_W        = 8,
  parameter int INIT_OFFSET = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [BM_W-1:0] bmS1S1,
  input  logic [BM_W-1:0] bmS1S2,
  input  logic [BM_W-1:0] bmS2S1,
  input  logic [BM_W-1:0] bmS2S2,
  output logic [1:0]      survivorBits,
  output logic            outValid,
  output logic [SM_W-1:0] metricS1,
  output logic [SM_W-1:0] metricS2
);
  acsCtrl_t ctrl;

  acs2_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  acs2_datapath #(.BM_W(BM_W), .SM_W(SM_W), .INIT_OFFSET(INIT_OFFSET)) dp_i (
    .clk       (clk),
    .ctrl      (ctrl),
    .bmS1S1    (bmS1S1),
    .bmS1S2    (bmS1S2),
    .bmS2S1    (bmS2S1),
    .bmS2S2    (bmS2S2),
    .decisionQ (survivorBits),
    .metricS1  (metricS1),
    .metricS2  (metricS2)
  );
endmodule

// File: tb/acs2_unit_tb_top.sv
module acs2_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [4:0] bmS1S1 = '0, bmS1S2 = '0, bmS2S1 = '0, bmS2S2 = '0;
  logic [1:0] survivorBits;
  logic outValid;
  logic [7:0] metricS1, metricS2;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int refS1 = 0, refS2 = 64;
  logic [1:0] refDec = 2'b00;

  always #10 clk = ~clk;

  acs2_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid),
    .bmS1S1(bmS1S1), .bmS1S2(bmS1S2), .bmS2S1(bmS2S1), .bmS2S2(bmS2S2),
    .survivorBits(survivorBits), .outValid(outValid),
    .metricS1(metricS1), .metricS2(metricS2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: unbounded metrics, ties keep the S1 path
  task automatic model(input int b11, input int b12, input int b21, input int b22);
    int a1, a2, c1, c2;
    a1 = refS1 + b11; a2 = refS2 + b21;
    c1 = refS1 + b12; c2 = refS2 + b22;
    refDec[0] = (a2 < a1);
    refDec[1] = (c2 < c1);
    refS1 = refDec[0] ? a2 : a1;
    refS2 = refDec[1] ? c2 : c1;
  endtask

  task automatic checkAll(input string tag);
    chk(metricS1 == 8'(refS1), {tag, " R2 S1 metric"}, metricS1, refS1 % 256);
    chk(metricS2 == 8'(refS2), {tag, " R3 S2 metric"}, metricS2, refS2 % 256);
    chk(survivorBits == refDec, {tag, " R4 decisions"}, survivorBits, refDec);
    chk(outValid == 1'b1, {tag, " R6 outValid"}, outValid, 1);
  endtask

  task automatic step(input int b11, input int b12, input int b21, input int b22,
                      input string tag);
    @(negedge clk);
    inValid = 1'b1;
    bmS1S1 = 5'(b11); bmS1S2 = 5'(b12); bmS2S1 = 5'(b21); bmS2S2 = 5'(b22);
    @(posedge clk);
    model(b11, b12, b21, b22);
    #5;
    checkAll(tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk); @(posedge clk);
    #5;
    refS1 = 0; refS2 = 64; refDec = 2'b00;
    chk(metricS1 == 8'd0, "R1 S1 reset", metricS1, 0);
    chk(metricS2 == 8'd64, "R1 S2 reset", metricS2, 64);
    chk(survivorBits == 2'b00, "R1 decisions reset", survivorBits, 0);
    chk(outValid == 1'b0, "R1 outValid reset", outValid, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_directed;
    step(3, 10, 0, 2, "dir1");    // both from S1
    step(31, 0, 0, 31, "dir2");   // S1 from S2, S2 from S1
    step(0, 31, 31, 0, "dir3");
    step(31, 31, 0, 0, "dir4");   // both from S2
    chk(survivorBits == 2'b11, "R4 both from S2", survivorBits, 3);
  endtask

  task automatic t_tie;
    for (int k = 0; k < 4; k++) begin
      int b11, b21, b12, b22;
      if (refS1 >= refS2) begin b11 = 0; b21 = refS1 - refS2; end
      else                begin b21 = 0; b11 = refS2 - refS1; end
      b12 = b11 + k; b22 = b21 + k;
      step(b11, b12, b21, b22, "tie");
      chk(survivorBits == 2'b00, "R5 tie keeps S1", survivorBits, 0);
    end
  endtask

  task automatic t_idle;
    logic [7:0] h1, h2;
    logic [1:0] hd;
    step(5, 1, 2, 9, "pre-idle");
    h1 = metricS1; h2 = metricS2; hd = survivorBits;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      bmS1S1 = 5'($urandom); bmS1S2 = 5'($urandom);
      bmS2S1 = 5'($urandom); bmS2S2 = 5'($urandom);
      @(posedge clk); #5;
      chk(metricS1 == h1, "R7 S1 held", metricS1, h1);
      chk(metricS2 == h2, "R7 S2 held", metricS2, h2);
      chk(survivorBits == hd, "R7 decisions held", survivorBits, hd);
      chk(outValid == 1'b0, "R7 outValid low", outValid, 0);
    end
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 < 100)
        step(31 - int'($urandom_range(2)), 31 - int'($urandom_range(2)),
             31 - int'($urandom_range(2)), 31 - int'($urandom_range(2)), "R8 wrap hi");
      else
        step(int'($urandom_range(31)), int'($urandom_range(31)),
             int'($urandom_range(31)), int'($urandom_range(31)), "R8 wrap rnd");
      chk(((refS1 - refS2) <= 64) && ((refS2 - refS1) <= 64), "R9 spread",
          refS1 - refS2, 0);
    end
    chk(refS1 > 256 * 20, "R8 wrapped many times", refS1, 256 * 20);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_directed();
    t_tie();
    t_idle();
    t_wrap();
    t_tie();
    t_idle();
    t_reset();
    step(7, 7, 7, 7, "after reset");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule